// File: doc/BRIEF.md
# Configurable edge event trigger controller

This block watches a set of asynchronous event lines and converts selected edges on them into interrupts, wakeup requests and CPU event requests for a two-CPU system. Each line is brought into the system clock domain by a two-flop synchronizer. Edge detection compares the current synchronized value with the value from the cycle before. Software picks the active edge for each line: rising, falling or both. Software can also fire a line directly through a self-clearing trigger register, which behaves like a rising edge whatever the edge selects hold.

One pending flag per line is shared by both CPUs and drives that line's interrupt output. A trigger sets the flag only when at least one CPU has the line's interrupt enabled. Either CPU clears it by writing 1. Each CPU also has an event mask. Enabled lines produce a one-cycle event request for that CPU, and they also produce a wakeup, even when no pending flag is set. The system wakeup is the OR of the per-CPU wakeups, so it stays high for as long as an enabled pending flag remains set.

Configuration goes through a simple synchronous port: a write strobe, a word address and write data, plus a read-data bus driven combinationally from the address.

Top module: `edge_trig_ctrl`

## Requirements
- R1: A rising edge on a line whose rising select bit is 1 is a trigger. The line is sampled through two flops, so the pending flag appears on the third clock edge after the input changes.
- R2: A falling edge on a line whose falling select bit is 1 is a trigger. A line with both select bits set triggers on each of its edges. A line with neither bit set ignores its edges.
- R3: Writing 1 to a bit of the software trigger register (word 2) is a trigger on that line in the write cycle, whatever the edge selects hold. Writing 0 does nothing, and the register always reads 0.
- R4: A trigger sets the line's pending flag only when the interrupt mask bit for that line is 1 for at least one CPU. Writing 1 to a bit of the pending register (word 3) clears it. If a trigger and a clear hit the same bit in one cycle, the set wins. `line_irq` mirrors the pending flags.
- R5: When the interrupt masks for a line are 0 for both CPUs and the event mask of CPU c is 1, a trigger raises `cpu_evt[c]` and `cpu_wake[c]` and leaves the pending flag clear.
- R6: When all interrupt and event masks for a line are 0, a trigger on it changes no output and no register.
- R7: `cpu_evt[c]` is high for exactly the one cycle after a cycle in which any line triggered with CPU c's event mask bit set.
- R8: `cpu_wake[c]` is high in the cycle after a trigger on a line where CPU c has the interrupt or the event enabled. It is also high while any pending flag is set whose CPU c interrupt mask bit is 1.
- R9: `sys_wake` is the OR of the `cpu_wake` bits.
- R10: After reset all registers read 0 and all outputs are 0.
- R11: A hardware edge that falls in the same cycle as a write to the rising or falling select register is not a trigger.
- R12: Register words are: 0 rising select, 1 falling select, 2 software trigger, 3 pending, then for CPU c word 4+2c is the interrupt mask and word 5+2c is the event mask. Bit i of each word belongs to line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | LINES | Asynchronous event lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | LINES | Register write data |
| reg_rdata | output | LINES | Read data for `reg_addr` |
| line_irq | output | LINES | Per-line interrupt shared by both CPUs |
| cpu_evt | output | CPUS | Per-CPU one-cycle event request |
| cpu_wake | output | CPUS | Per-CPU wakeup request |
| sys_wake | output | 1 | System wakeup request |

## Verification
The assertions assume that a write lasts one cycle and targets a single word. Since the address width covers exactly the mapped words, every write has a defined effect. They also assume that line levels reach the first synchronizer flop with no ordering against the configuration port. The stimulus changes inputs one nanosecond after each rising edge and holds each write strobe for exactly one cycle. Line toggles and writes to any of the eight words with any data are mixed at random, including select writes that land on edge cycles and pending clears that coincide with new triggers.

// File: rtl/etc_pkg.sv
`timescale 1ns/1ps
package etc_pkg;
    localparam int OFS_RISE      = 0;
    localparam int OFS_FALL      = 1;
    localparam int OFS_SWTRIG    = 2;
    localparam int OFS_PEND      = 3;
    localparam int OFS_MASK_BASE = 4;
    localparam int WORDS_PER_CPU = 2;

    function automatic int im_ofs(input int cpu);
        return OFS_MASK_BASE + WORDS_PER_CPU * cpu;
    endfunction

    function automatic int em_ofs(input int cpu);
        return OFS_MASK_BASE + WORDS_PER_CPU * cpu + 1;
    endfunction
endpackage

// File: rtl/etc_sync_edge.sv
`timescale 1ns/1ps
module etc_sync_edge #(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);
    typedef struct packed {
        logic [LINES-1:0] meta;
        logic [LINES-1:0] cur;
        logic [LINES-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = line_in;
        st_d.cur  = st_q.meta;
        st_d.prev = st_q.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < LINES; i++) begin : g_edge
        assign rise_o[i] =  st_q.cur[i] & ~st_q.prev[i];
        assign fall_o[i] = ~st_q.cur[i] &  st_q.prev[i];
    end
endmodule

// File: rtl/etc_regs.sv
`timescale 1ns/1ps
module etc_regs
    import etc_pkg::*;
#(
    parameter int LINES = 8,
    parameter int CPUS  = 2,
    parameter int AW    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_i,
    input  logic [AW-1:0]              addr_i,
    input  logic [LINES-1:0]           wdata_i,
    input  logic [LINES-1:0]           pend_i,
    output logic [LINES-1:0]           rsel_o,
    output logic [LINES-1:0]           fsel_o,
    output logic [CPUS-1:0][LINES-1:0] im_o,
    output logic [CPUS-1:0][LINES-1:0] em_o,
    output logic [LINES-1:0]           swt_o,
    output logic [LINES-1:0]           clr_o,
    output logic                       sel_wr_o,
    output logic [LINES-1:0]           rdata_o
);
    typedef struct packed {
        logic [LINES-1:0]           rise;
        logic [LINES-1:0]           fall;
        logic [CPUS-1:0][LINES-1:0] im;
        logic [CPUS-1:0][LINES-1:0] em;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d    = cfg_q;
        swt_o    = '0;
        clr_o    = '0;
        sel_wr_o = 1'b0;
        if (wr_i) begin
            if (addr_i == AW'(OFS_RISE)) begin
                cfg_d.rise = wdata_i;
                sel_wr_o   = 1'b1;
            end
            if (addr_i == AW'(OFS_FALL)) begin
                cfg_d.fall = wdata_i;
                sel_wr_o   = 1'b1;
            end
            if (addr_i == AW'(OFS_SWTRIG)) swt_o = wdata_i;
            if (addr_i == AW'(OFS_PEND))   clr_o = wdata_i;
            for (int c = 0; c < CPUS; c++) begin
                if (addr_i == AW'(im_ofs(c))) cfg_d.im[c] = wdata_i;
                if (addr_i == AW'(em_ofs(c))) cfg_d.em[c] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == AW'(OFS_RISE)) rdata_o = cfg_q.rise;
        if (addr_i == AW'(OFS_FALL)) rdata_o = cfg_q.fall;
        if (addr_i == AW'(OFS_PEND)) rdata_o = pend_i;
        for (int c = 0; c < CPUS; c++) begin
            if (addr_i == AW'(im_ofs(c))) rdata_o = cfg_q.im[c];
            if (addr_i == AW'(em_ofs(c))) rdata_o = cfg_q.em[c];
        end
    end

    assign rsel_o = cfg_q.rise;
    assign fsel_o = cfg_q.fall;
    assign im_o   = cfg_q.im;
    assign em_o   = cfg_q.em;

    AST_SWTRIG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == AW'(OFS_SWTRIG)) |-> (rdata_o == '0)); // R3
endmodule

// File: rtl/etc_route.sv
`timescale 1ns/1ps
module etc_route #(
    parameter int LINES = 8,
    parameter int CPUS  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [LINES-1:0]           rise_i,
    input  logic [LINES-1:0]           fall_i,
    input  logic [LINES-1:0]           rsel_i,
    input  logic [LINES-1:0]           fsel_i,
    input  logic [LINES-1:0]           swt_i,
    input  logic [LINES-1:0]           clr_i,
    input  logic                       sel_wr_i,
    input  logic [CPUS-1:0][LINES-1:0] im_i,
    input  logic [CPUS-1:0][LINES-1:0] em_i,
    output logic [LINES-1:0]           pend_o,
    output logic [CPUS-1:0]            evt_o,
    output logic [CPUS-1:0]            wake_o,
    output logic                       sys_wake_o
);
    typedef struct packed {
        logic [LINES-1:0] pend;
        logic [CPUS-1:0]  evt;
        logic [CPUS-1:0]  wpulse;
    } route_t;

    route_t rt_d, rt_q;
    logic [LINES-1:0] hw_fire;
    logic [LINES-1:0] fire;
    logic [LINES-1:0] any_im;

    always_comb begin
        any_im = '0;
        for (int c = 0; c < CPUS; c++) any_im = any_im | im_i[c];
        hw_fire = sel_wr_i ? '0 : ((rise_i & rsel_i) | (fall_i & fsel_i));
        fire    = hw_fire | swt_i;
        rt_d      = rt_q;
        rt_d.pend = (rt_q.pend & ~clr_i) | (fire & any_im);
        for (int c = 0; c < CPUS; c++) begin
            rt_d.evt[c]    = |(fire & em_i[c]);
            rt_d.wpulse[c] = |(fire & (im_i[c] | em_i[c]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rt_q <= '0;
        else        rt_q <= rt_d;
    end

    for (genvar c = 0; c < CPUS; c++) begin : g_cpu
        assign wake_o[c] = rt_q.wpulse[c] | (|(rt_q.pend & im_i[c]));

        AST_EVT_NEEDS_EM: assert property (@(posedge clk) disable iff (!rst_n)
            rt_q.evt[c] |-> ($past(em_i[c]) != '0)); // R7
        AST_WAKE_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            wake_o[c] |-> ((im_i[c] | em_i[c] | $past(im_i[c] | em_i[c])) != '0)); // R8
    end

    assign pend_o     = rt_q.pend;
    assign evt_o      = rt_q.evt;
    assign sys_wake_o = |wake_o;

    AST_PEND_NEEDS_IM: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_q.pend & ~$past(rt_q.pend) & ~$past(any_im)) == '0); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_q.pend & $past(clr_i & ~fire)) == '0); // R4
    AST_SEL_WRITE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sel_wr_i) |-> ((rt_q.pend & ~$past(rt_q.pend)) == '0)); // R11
    AST_SYS_WAKE_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rt_q.pend & any_im)) |-> sys_wake_o); // R9
endmodule

// File: rtl/edge_trig_ctrl.sv
`timescale 1ns/1ps
module edge_trig_ctrl #(
    parameter  int LINES = 8,
    parameter  int CPUS  = 2,
    localparam int AW    = $clog2(etc_pkg::OFS_MASK_BASE + etc_pkg::WORDS_PER_CPU * CPUS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [LINES-1:0] reg_wdata,
    output logic [LINES-1:0] reg_rdata,
    output logic [LINES-1:0] line_irq,
    output logic [CPUS-1:0]  cpu_evt,
    output logic [CPUS-1:0]  cpu_wake,
    output logic             sys_wake
);
    logic [LINES-1:0]           rise_w, fall_w, rsel_w, fsel_w, swt_w, clr_w, pend_w;
    logic [CPUS-1:0][LINES-1:0] im_w, em_w;
    logic                       sel_wr_w;

    etc_sync_edge #(.LINES(LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_in),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    etc_regs #(.LINES(LINES), .CPUS(CPUS), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr),
        .addr_i   (reg_addr),
        .wdata_i  (reg_wdata),
        .pend_i   (pend_w),
        .rsel_o   (rsel_w),
        .fsel_o   (fsel_w),
        .im_o     (im_w),
        .em_o     (em_w),
        .swt_o    (swt_w),
        .clr_o    (clr_w),
        .sel_wr_o (sel_wr_w),
        .rdata_o  (reg_rdata)
    );

    etc_route #(.LINES(LINES), .CPUS(CPUS)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise_w),
        .fall_i     (fall_w),
        .rsel_i     (rsel_w),
        .fsel_i     (fsel_w),
        .swt_i      (swt_w),
        .clr_i      (clr_w),
        .sel_wr_i   (sel_wr_w),
        .im_i       (im_w),
        .em_i       (em_w),
        .pend_o     (pend_w),
        .evt_o      (cpu_evt),
        .wake_o     (cpu_wake),
        .sys_wake_o (sys_wake)
    );

    assign line_irq = pend_w;
endmodule

// File: tb/edge_trig_ctrl_bench.sv
`timescale 1ns/1ps
module edge_trig_ctrl_bench;
    localparam int L  = 8;
    localparam int C  = 2;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [L-1:0]  line_in = '0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [L-1:0]  reg_wdata = '0;
    logic [L-1:0]  reg_rdata, line_irq;
    logic [C-1:0]  cpu_evt, cpu_wake;
    logic          sys_wake;

    int n_run = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_trig_ctrl #(.LINES(L), .CPUS(C)) u_edge_trig_ctrl (
        .clk(clk), .rst_n(rst_n), .line_in(line_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .line_irq(line_irq), .cpu_evt(cpu_evt), .cpu_wake(cpu_wake), .sys_wake(sys_wake)
    );

    // behavioural reference state
    logic [L-1:0] h0, h1, h2;            // input history: last three samples
    logic [L-1:0] m_rs, m_fs, m_pend;
    logic [C-1:0][L-1:0] m_im, m_em;
    logic [C-1:0] m_evt, m_wp;
    logic [L-1:0] f_hw, f_all, f_anyim, f_next;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h0 = '0; h1 = '0; h2 = '0;
            m_rs = '0; m_fs = '0; m_pend = '0;
            m_im = '0; m_em = '0; m_evt = '0; m_wp = '0;
        end else begin
            f_hw = (h1 & ~h2 & m_rs) | (~h1 & h2 & m_fs);
            if (reg_wr && (reg_addr == 3'd0 || reg_addr == 3'd1)) f_hw = '0;
            f_all = f_hw | ((reg_wr && reg_addr == 3'd2) ? reg_wdata : '0);
            f_anyim = m_im[0] | m_im[1];
            for (int c = 0; c < C; c++) begin
                m_evt[c] = (f_all & m_em[c]) != '0;
                m_wp[c]  = (f_all & (m_im[c] | m_em[c])) != '0;
            end
            f_next = m_pend;
            if (reg_wr && reg_addr == 3'd3) f_next = f_next & ~reg_wdata;
            m_pend = f_next | (f_all & f_anyim);
            if (reg_wr) begin
                case (reg_addr)
                    3'd0: m_rs = reg_wdata;
                    3'd1: m_fs = reg_wdata;
                    3'd4: m_im[0] = reg_wdata;
                    3'd5: m_em[0] = reg_wdata;
                    3'd6: m_im[1] = reg_wdata;
                    3'd7: m_em[1] = reg_wdata;
                    default: ;
                endcase
            end
            h2 = h1; h1 = h0; h0 = line_in;
        end
    end

    function automatic logic [C-1:0] exp_wake();
        logic [C-1:0] w;
        for (int c = 0; c < C; c++) w[c] = m_wp[c] | ((m_pend & m_im[c]) != '0);
        return w;
    endfunction

    function automatic logic [L-1:0] exp_rd(input logic [AW-1:0] a);
        case (a)
            3'd0: return m_rs;
            3'd1: return m_fs;
            3'd3: return m_pend;
            3'd4: return m_im[0];
            3'd5: return m_em[0];
            3'd6: return m_im[1];
            3'd7: return m_em[1];
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            chk("R4 line_irq vs model", 32'(line_irq), 32'(m_pend));
            chk("R7 cpu_evt vs model", 32'(cpu_evt), 32'(m_evt));
            chk("R8 cpu_wake vs model", 32'(cpu_wake), 32'(exp_wake()));
            chk("R9 sys_wake vs model", 32'(sys_wake), 32'(|exp_wake()));
            chk("R12 reg_rdata vs model", 32'(reg_rdata), 32'(exp_rd(reg_addr)));
        end
    end

    task automatic wr(input int a, input int d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = L'(d);
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic set_line(input int i, input logic v);
        @(posedge clk); #1;
        line_in[i] = v;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rd_chk(input string tag, input int a, input int e);
        @(posedge clk); #1;
        reg_addr = AW'(a);
        @(negedge clk);
        chk(tag, 32'(reg_rdata), 32'(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk); #1;
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 line_irq after reset", 32'(line_irq), 0);
        chk("R10 cpu_wake after reset", 32'(cpu_wake), 0);
        chk("R10 sys_wake after reset", 32'(sys_wake), 0);
        for (int a = 0; a < 8; a++) rd_chk("R10 register reads 0 after reset", a, 0);

        // R12: map
        wr(0, 'h2B); wr(1, 'h0C); wr(4, 'h09); wr(5, 'h00); wr(6, 'h04); wr(7, 'h02);
        rd_chk("R12 word 6 is CPU1 interrupt mask", 6, 'h04);
        rd_chk("R12 word 1 is falling select", 1, 'h0C);
        rd_chk("R12 word 7 is CPU1 event mask", 7, 'h02);

        // R1: rising edge on line 0
        set_line(0, 1'b1); settle(3);
        chk("R1 rising edge sets pending line 0", 32'(line_irq), 'h01);
        chk("R8 CPU0 wake from pending", 32'(cpu_wake), 'b01);
        chk("R9 sys_wake high", 32'(sys_wake), 1);
        rd_chk("R4 pending reads back", 3, 'h01);
        wr(3, 'h01); @(negedge clk);
        chk("R4 write 1 clears pending", 32'(line_irq), 0);

        // R5: event-only line 1 for CPU1
        set_line(1, 1'b1); settle(3);
        chk("R5 event-only gives cpu_evt[1]", 32'(cpu_evt), 'b10);
        chk("R5 event-only gives cpu_wake[1]", 32'(cpu_wake), 'b10);
        chk("R5 event-only leaves pending clear", 32'(line_irq), 0);
        settle(1);
        chk("R7 cpu_evt lasts one cycle", 32'(cpu_evt), 0);

        // R2: falling only on line 2, both edges on line 3
        set_line(2, 1'b1); settle(3);
        chk("R2 rising edge ignored on falling-only line", 32'(line_irq), 0);
        set_line(2, 1'b0); settle(3);
        chk("R2 falling edge sets pending line 2", 32'(line_irq), 'h04);
        chk("R8 CPU1 wake only", 32'(cpu_wake), 'b10);
        wr(3, 'h04);
        set_line(3, 1'b1); settle(3);
        chk("R2 both-edge line rising", 32'(line_irq), 'h08);
        wr(3, 'h08);
        set_line(3, 1'b0); settle(3);
        chk("R2 both-edge line falling", 32'(line_irq), 'h08);
        wr(3, 'h08);

        // R6: fully masked line 5
        set_line(5, 1'b1); settle(3);
        chk("R6 masked line no irq", 32'(line_irq), 0);
        chk("R6 masked line no evt", 32'(cpu_evt), 0);
        chk("R6 masked line no wake", 32'(cpu_wake), 0);
        rd_chk("R6 masked line leaves pending clear", 3, 0);
        set_line(5, 1'b0); settle(3);
        chk("R6 masked line falling no irq", 32'(line_irq), 0);

        // R3: software trigger on line 4 (no edge select)
        wr(4, 'h19);
        wr(2, 'h10); @(negedge clk);
        chk("R3 software trigger sets pending", 32'(line_irq), 'h10);
        rd_chk("R3 software trigger reads 0", 2, 0);
        wr(3, 'h10);
        wr(2, 'h00); @(negedge clk);
        chk("R3 writing 0 has no effect", 32'(line_irq), 0);

        // R11: edge coinciding with a select write
        set_line(0, 1'b0); settle(3);
        set_line(0, 1'b1);
        @(posedge clk);
        wr(0, 'h2B);
        settle(1);
        chk("R11 edge during select write ignored", 32'(line_irq), 0);

        // random mix, compared against model every cycle
        for (int k = 0; k < 2000; k++) begin
            @(posedge clk); #1;
            if ($urandom_range(3) == 0) line_in[$urandom_range(L-1)] ^= 1'b1;
            reg_wr = ($urandom_range(3) == 0);
            reg_addr = AW'($urandom_range(7));
            reg_wdata = L'($urandom);
        end
        @(posedge clk); #1;
        reg_wr = 1'b0;
        settle(4);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule